// File: doc/BRIEF.md
# Codec Serial Port, Frame-Sync Slave Engine

This block is the receive and transmit engine of a serial port that talks to an external audio or data converter. The converter owns the bit clock and the frame-sync line, and this engine follows them. The frame-sync line passes through a synchronizer and is watched on every rising bit-clock edge. A sync event starts one data frame. In frame-pulse mode and tag-frame mode the event is a high level. In I2S mode the event is a change of level in either direction. Once a frame has started, the engine shifts transmit words out and receive words in, most significant bit first, until the programmed number of words has been moved.

On the parallel side the engine has two valid/ready channels. Transmit has a one-word holding register and receive has a one-word output register. Word size and words per frame are set by two configuration inputs and are captured when each frame starts. Two sticky flags report a missing transmit word and a lost receive word. A one-cycle pulse marks the end of every frame. Sync events that arrive while a frame is running are dropped.

Top module: `csi_slave`

## Requirements
- R1: While `rst` is high at a rising edge, and right after it, `sdo` is 0, `frame_done`, `rx_valid`, `underflow` and `overflow` are 0, and `tx_ready` is 1.
- R2: With `mode_sel` = 0 (frame-pulse mode), if `fs_in` is high at rising edge k, the first bit of the frame is exchanged at rising edge k+3. Both sides sample it there, and the remaining bits follow on consecutive rising edges.
- R3: With `mode_sel` = 1 (I2S mode), a level change on `fs_in` starts a frame. The change is seen when `fs_in` differs at edge k from its value at edge k-1, and the first bit is exchanged at rising edge k+3. A rising change and a falling change both start a frame.
- R4: With `mode_sel` = 2 (tag-frame mode), a high `fs_in` starts a frame with the same latency. Its first slot is a 16-bit tag, followed by `frame_words`-1 slots of the programmed word size.
- R5: Every word is sent MSB first. `word_size` gives bits per word in the range 4 to 16: values below 4 act as 4 and values above 16 act as 16. `frame_words` gives words per frame in the range 1 to 16: 0 acts as 1. Both inputs are captured when a frame starts, and changing them mid-frame has no effect on that frame.
- R6: Each received word appears right-aligned on `rx_data` with zero upper bits, first bit as MSB. `rx_valid` rises after the word's last bit and stays high with stable data until the handshake with `rx_ready`.
- R7: A sync event (a level or a change) during a running frame neither restarts nor lengthens it, and it does not start a further frame afterwards.
- R8: A transmit word is taken when `tx_valid` and `tx_ready` are both high. If no word is held when a word starts, zeros are sent in its place and `underflow` goes high and stays high until reset.
- R9: If a new receive word completes while `rx_valid` is high and `rx_ready` is low, the new word replaces the old one and `overflow` goes high and stays high until reset.
- R10: `frame_done` is high for exactly one cycle, directly after the rising edge at which the last bit of the frame is exchanged.
- R11: `sdo` changes only on the falling bit-clock edge and is 0 outside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the converter |
| rst | input | 1 | Synchronous active-high reset |
| fs_in | input | 1 | Frame-sync line from the converter |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data, updated on the falling edge |
| mode_sel | input | 2 | 0 frame-pulse, 1 I2S, 2 tag-frame |
| word_size | input | 5 | Bits per data word (4 to 16) |
| frame_words | input | 5 | Words per frame (1 to 16) |
| tx_data | input | 16 | Transmit word, right-aligned |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Received word taken |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| underflow | output | 1 | Sticky: a word went out as zeros |
| overflow | output | 1 | Sticky: a received word was overwritten |

## Verification
The bench sweeps every word size with several frame lengths in each mode and predicts each serial bit, its cycle and the end pulse by arithmetic. A latency error in the synchronizer or the start logic therefore shows up as every bit landing one cycle off. In I2S mode it toggles the sync line, so frames start on falling and on rising changes alike. A design that reacted to only one direction would miss every second frame. It pulses or toggles sync mid-frame to catch an engine that restarts or stretches the frame. It changes the configuration inputs mid-frame to catch one that does not hold its settings. Frames with no transmit data and with a stalled receiver check for zero fill, the newest-word-wins rule and the sticky flags.

// File: rtl/csi_pkg.sv
`timescale 1ns/1ps
package csi_pkg;

    localparam int CSI_DW        = 16;
    localparam int CSI_MIN_WORD  = 4;
    localparam int CSI_MAX_WORDS = 16;
    localparam int CSI_CW        = $clog2(CSI_DW + 1);
    localparam int CSI_NW        = $clog2(CSI_MAX_WORDS + 1);

    typedef enum logic [1:0] {
        FS_PULSE  = 2'd0,
        FS_I2S    = 2'd1,
        FS_TAGGED = 2'd2,
        FS_SPARE  = 2'd3
    } fs_mode_e;

    typedef struct packed {
        fs_mode_e            mode;
        logic [CSI_CW-1:0]   wsize;
        logic [CSI_NW-1:0]   nwords;
    } frame_cfg_t;

    function automatic logic [CSI_CW-1:0] fit_len(input logic [CSI_CW-1:0] v);
        if (v < CSI_CW'(CSI_MIN_WORD))
            return CSI_CW'(CSI_MIN_WORD);
        else if (v > CSI_CW'(CSI_DW))
            return CSI_CW'(CSI_DW);
        else
            return v;
    endfunction

    function automatic logic [CSI_NW-1:0] fit_words(input logic [CSI_NW-1:0] v);
        if (v == '0)
            return CSI_NW'(1);
        else if (v > CSI_NW'(CSI_MAX_WORDS))
            return CSI_NW'(CSI_MAX_WORDS);
        else
            return v;
    endfunction

    function automatic logic [CSI_DW-1:0] low_mask(input logic [CSI_CW-1:0] n);
        logic [CSI_DW-1:0] m;
        for (int i = 0; i < CSI_DW; i++)
            m[i] = (i < int'(n));
        return m;
    endfunction

endpackage

// File: rtl/csi_sync_detect.sv
`timescale 1ns/1ps
module csi_sync_detect
    import csi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     fs_in,
    input  fs_mode_e mode,
    output logic     sync_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], fs_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_comb begin
        if (mode == FS_I2S)
            sync_evt = level ^ prev_q;
        else
            sync_evt = level;
    end

endmodule

// File: rtl/csi_frame_ctrl.sv
`timescale 1ns/1ps
module csi_frame_ctrl
    import csi_pkg::*;
#(
    parameter int TAG_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_evt,
    input  frame_cfg_t        cfg_in,
    output logic              busy,
    output logic              load,
    output logic [CSI_CW-1:0] load_len,
    output logic              word_done,
    output logic [CSI_CW-1:0] cur_len,
    output logic              frame_done
);

    localparam logic [CSI_CW-1:0] TAG_LEN = CSI_CW'(TAG_BITS);

    frame_cfg_t        cfg_q;
    logic [CSI_CW-1:0] bit_cnt;
    logic [CSI_NW-1:0] word_cnt;
    logic              start;
    logic              last_word;
    logic              frame_end;

    always_comb begin
        start     = sync_evt && !busy;
        cur_len   = (cfg_q.mode == FS_TAGGED && word_cnt == '0) ? TAG_LEN : cfg_q.wsize;
        word_done = busy && (bit_cnt == cur_len - 1'b1);
        last_word = (word_cnt == cfg_q.nwords - 1'b1);
        frame_end = word_done && last_word;
        load      = start || (word_done && !last_word);
        if (start)
            load_len = (cfg_in.mode == FS_TAGGED) ? TAG_LEN : fit_len(cfg_in.wsize);
        else
            load_len = cfg_q.wsize;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cfg_q      <= '0;
            bit_cnt    <= '0;
            word_cnt   <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_end;
            if (start) begin
                busy         <= 1'b1;
                cfg_q.mode   <= cfg_in.mode;
                cfg_q.wsize  <= fit_len(cfg_in.wsize);
                cfg_q.nwords <= fit_words(cfg_in.nwords);
                bit_cnt      <= '0;
                word_cnt     <= '0;
            end else if (word_done) begin
                bit_cnt  <= '0;
                word_cnt <= word_cnt + 1'b1;
                if (last_word)
                    busy <= 1'b0;
            end else if (busy) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R10: end pulse lasts one cycle and leaves the engine idle
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> !busy);
    // R5: bit counter stays inside the current word
    a_r5_bit_in_word: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_cnt < cur_len));
    // R5: captured settings hold for the whole frame
    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_end) |=> $stable(cfg_q));
    // R7: a running frame is never cut short
    a_r7_busy_until_end: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_end) |=> busy);

endmodule

// File: rtl/csi_shifter.sv
`timescale 1ns/1ps
module csi_shifter
    import csi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CSI_DW-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              sdi,
    input  logic              rx_ready,
    output logic [CSI_DW-1:0] rx_data,
    output logic              rx_valid,
    input  logic              busy,
    input  logic              load,
    input  logic [CSI_CW-1:0] load_len,
    input  logic              word_done,
    input  logic [CSI_CW-1:0] cur_len,
    output logic              sdo,
    output logic              underflow,
    output logic              overflow
);

    logic [CSI_DW-1:0] hold_q;
    logic              hold_full;
    logic [CSI_DW-1:0] tx_sh;
    logic [CSI_DW-1:0] rx_sh;
    logic [CSI_DW-1:0] rx_next;
    logic [CSI_CW-1:0] align;

    assign tx_ready = !hold_full;
    assign rx_next  = {rx_sh[CSI_DW-2:0], sdi};
    assign align    = CSI_CW'(CSI_DW) - load_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            if (load)
                hold_full <= 1'b0;
            if (tx_valid && !hold_full) begin
                hold_q    <= tx_data;
                hold_full <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh     <= '0;
            underflow <= 1'b0;
        end else if (load) begin
            tx_sh <= (hold_full ? hold_q : '0) << align;
            if (!hold_full)
                underflow <= 1'b1;
        end else if (busy) begin
            tx_sh <= tx_sh << 1;
        end
    end

    always_ff @(negedge clk) begin
        if (rst)
            sdo <= 1'b0;
        else
            sdo <= busy ? tx_sh[CSI_DW-1] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
            overflow <= 1'b0;
        end else begin
            if (busy)
                rx_sh <= rx_next;
            if (word_done) begin
                rx_data  <= rx_next & low_mask(cur_len);
                rx_valid <= 1'b1;
                if (rx_valid && !rx_ready)
                    overflow <= 1'b1;
            end else if (rx_valid && rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    // R8: underflow flag is sticky
    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);
    // R8: a held word is kept until a word boundary takes it
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (!tx_ready && !load) |=> !tx_ready);
    // R9: overflow flag is sticky
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);
    // R6: an unconsumed word stays valid and stable
    a_r6_rx_held: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);
    a_r6_rx_stable: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready && !word_done) |=> $stable(rx_data));

endmodule

// File: rtl/csi_slave.sv
`timescale 1ns/1ps
module csi_slave
    import csi_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TAG_BITS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_in,
    input  logic              sdi,
    output logic              sdo,
    input  logic [1:0]        mode_sel,
    input  logic [CSI_CW-1:0] word_size,
    input  logic [CSI_NW-1:0] frame_words,
    input  logic [CSI_DW-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [CSI_DW-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic              frame_done,
    output logic              underflow,
    output logic              overflow
);

    frame_cfg_t        cfg_in;
    logic              sync_evt;
    logic              busy;
    logic              load;
    logic [CSI_CW-1:0] load_len;
    logic              word_done;
    logic [CSI_CW-1:0] cur_len;

    always_comb begin
        cfg_in.mode   = fs_mode_e'(mode_sel);
        cfg_in.wsize  = word_size;
        cfg_in.nwords = frame_words;
    end

    csi_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fs_in    (fs_in),
        .mode     (cfg_in.mode),
        .sync_evt (sync_evt)
    );

    csi_frame_ctrl #(.TAG_BITS(TAG_BITS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sync_evt   (sync_evt),
        .cfg_in     (cfg_in),
        .busy       (busy),
        .load       (load),
        .load_len   (load_len),
        .word_done  (word_done),
        .cur_len    (cur_len),
        .frame_done (frame_done)
    );

    csi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .sdi       (sdi),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .busy      (busy),
        .load      (load),
        .load_len  (load_len),
        .word_done (word_done),
        .cur_len   (cur_len),
        .sdo       (sdo),
        .underflow (underflow),
        .overflow  (overflow)
    );

endmodule

// File: tb/csi_slave_test.sv
`timescale 1ns/1ps
module csi_slave_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        fs_in;
    logic        sdi;
    logic        sdo;
    logic [1:0]  mode_sel;
    logic [4:0]  word_size;
    logic [4:0]  frame_words;
    logic [15:0] tx_data;
    logic        tx_valid;
    logic        tx_ready;
    logic [15:0] rx_data;
    logic        rx_valid;
    logic        rx_ready;
    logic        frame_done;
    logic        underflow;
    logic        overflow;

    always #2.5 clk = ~clk;

    csi_slave uut (
        .clk(clk), .rst(rst), .fs_in(fs_in), .sdi(sdi), .sdo(sdo),
        .mode_sel(mode_sel), .word_size(word_size), .frame_words(frame_words),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .frame_done(frame_done), .underflow(underflow), .overflow(overflow)
    );

    int total = 0;
    int bad   = 0;
    int fid   = 0;
    bit fs_lvl;
    bit finished = 0;
    int txw [0:15];
    int rxw [0:15];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int fitw(input int v);
        if (v < 4) return 4;
        if (v > 16) return 16;
        return v;
    endfunction

    function automatic int fitn(input int v);
        if (v < 1) return 1;
        if (v > 16) return 16;
        return v;
    endfunction

    function automatic string mreq(input int md);
        if (md == 1) return "R3";
        if (md == 2) return "R4";
        return "R2";
    endfunction

    task automatic win();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; fs_in = 1'b0; fs_lvl = 1'b0; sdi = 1'b0;
        tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b1;
        mode_sel = 2'd0; word_size = 5'd8; frame_words = 5'd1;
        repeat (3) @(posedge clk);
        win();
        chk(sdo == 1'b0, "R1 sdo", sdo, 0);
        chk(frame_done == 1'b0 && rx_valid == 1'b0, "R1 done/rx_valid",
            {frame_done, rx_valid}, 0);
        chk(underflow == 1'b0 && overflow == 1'b0, "R1 flags", {underflow, overflow}, 0);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        rst = 1'b0;
    endtask

    task automatic run_frame(input int md, input int ws_raw, input int nw_raw,
                             input bit give_tx, input bit rdy, input bit poke);
        int ws = fitw(ws_raw);
        int nw = fitn(nw_raw);
        int L  = (md == 2) ? 16 + (nw - 1) * ws : nw * ws;
        int next_tx = 0;
        int rx_idx  = 0;
        fid++;
        for (int w = 0; w < nw; w++) begin
            int len = (md == 2 && w == 0) ? 16 : ws;
            txw[w] = (w * 149 + ws * 23 + fid * 71 + 13) & ((1 << len) - 1);
            rxw[w] = (w * 97 + ws * 41 + fid * 53 + 29) & ((1 << len) - 1);
        end
        mode_sel = md[1:0]; word_size = ws_raw[4:0]; frame_words = nw_raw[4:0];
        rx_ready = rdy;
        if (give_tx) begin
            tx_valid = 1'b1; tx_data = txw[0][15:0]; next_tx = 1;
        end
        for (int c = 0; c <= L + 6; c++) begin
            int p = c - 3;
            int w = 0;
            int b = 0;
            int len = ws;
            int exp_o = 0;
            int exp_i = 0;
            win();
            tx_valid = 1'b0;
            if (p >= 0 && p < L) begin
                if (md == 2 && p < 16) begin
                    w = 0; b = p; len = 16;
                end else if (md == 2) begin
                    w = 1 + (p - 16) / ws; b = (p - 16) % ws; len = ws;
                end else begin
                    w = p / ws; b = p % ws; len = ws;
                end
                exp_o = give_tx ? ((txw[w] >> (len - 1 - b)) & 1) : 0;
                exp_i = (rxw[w] >> (len - 1 - b)) & 1;
                chk(sdo == exp_o[0], give_tx ? {mreq(md), "/R5 sdo bit"} : "R8 zero fill",
                    sdo, exp_o);
            end else begin
                chk(sdo == 1'b0, "R11 sdo idle", sdo, 0);
            end
            chk(frame_done == (c == 3 + L), "R10 frame_done", frame_done, (c == 3 + L));
            if (rx_valid && rdy) begin
                if (rx_idx < nw)
                    chk(rx_data == rxw[rx_idx][15:0], "R6 rx word", rx_data, rxw[rx_idx]);
                else
                    chk(1'b0, "R6 extra rx word", rx_idx, nw);
                rx_idx++;
            end
            if (md == 1) begin
                if (c == 0 || (poke && c == 6)) fs_lvl = ~fs_lvl;
                fs_in = fs_lvl;
            end else begin
                fs_in = (c == 0) || (poke && c == 6);
            end
            sdi = exp_i[0];
            if (give_tx && tx_ready && next_tx < nw) begin
                tx_valid = 1'b1; tx_data = txw[next_tx][15:0]; next_tx++;
            end
            if (c == 4) begin
                word_size = ws_raw[4:0] ^ 5'd7;
                frame_words = 5'd1;
            end
        end
        tx_valid = 1'b0;
        if (rdy) begin
            chk(rx_idx == nw, "R6 word count", rx_idx, nw);
        end else begin
            chk(overflow == (nw > 1), "R9 overflow", overflow, (nw > 1));
            chk(rx_valid == 1'b1 && rx_data == rxw[nw-1][15:0], "R9 newest word",
                rx_data, rxw[nw-1]);
        end
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // frame-pulse mode sweep (R2, R5, R6, R10, R11)
        for (int ws = 4; ws <= 16; ws++) begin
            run_frame(0, ws, 1, 1, 1, 0);
            run_frame(0, ws, 2, 1, 1, 0);
            run_frame(0, ws, 3, 1, 1, 0);
            run_frame(0, ws, 5, 1, 1, 0);
        end
        chk(underflow == 1'b0, "R8 no underflow when fed", underflow, 0);
        chk(overflow == 1'b0, "R9 no overflow when drained", overflow, 0);
        // R5 clamping of configuration values
        run_frame(0, 2, 3, 1, 1, 0);
        run_frame(0, 25, 0, 1, 1, 0);
        run_frame(0, 4, 16, 1, 1, 0);
        // R7 mid-frame sync pulse
        run_frame(0, 6, 3, 1, 1, 1);

        do_reset();
        // I2S: alternating rising and falling changes (R3)
        for (int ws = 4; ws <= 16; ws++) begin
            run_frame(1, ws, 1, 1, 1, 0);
            run_frame(1, ws, 2, 1, 1, 0);
        end
        run_frame(1, 8, 2, 1, 1, 1);

        do_reset();
        // tag-frame mode (R4)
        for (int nw = 1; nw <= 4; nw++) begin
            run_frame(2, 4, nw, 1, 1, 0);
            run_frame(2, 9, nw, 1, 1, 0);
            run_frame(2, 16, nw, 1, 1, 0);
        end
        run_frame(2, 5, 3, 1, 1, 1);

        do_reset();
        // R8 underflow
        chk(underflow == 1'b0, "R8 clear before", underflow, 0);
        run_frame(0, 8, 2, 0, 1, 0);
        chk(underflow == 1'b1, "R8 underflow set", underflow, 1);
        run_frame(0, 8, 1, 1, 1, 0);
        chk(underflow == 1'b1, "R8 underflow sticky", underflow, 1);

        do_reset();
        // R9 overflow with stalled receiver
        run_frame(0, 4, 3, 1, 0, 0);
        win();
        chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule